// File: doc/BRIEF.md
# Vector Range Compare Unit

This block scans a 128-bit data vector element by element and classifies each element against a set of ranges. The ranges come from a second 128-bit vector of boundary values. A third 128-bit vector supplies one control byte per boundary. Consecutive boundaries are grouped two at a time. A data element lies inside a range only when it satisfies the acceptance rule of both boundaries in that group. Elements are 8, 16 or 32 bits wide. An optional zero search also finds the first all-zero data element.

A request arrives on a valid/ready input channel with all of its operands and mode bits. The unit is busy until the result has been taken, so back-pressure is simple. `in_ready` is high only while the unit is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Once the scan ends, `out_valid` goes high. The result and condition code then stay constant until `out_ready` is seen high on a clock edge, and the unit returns to idle on that edge. The scan handles one data element per cycle and evaluates all boundary groups in parallel.

The result takes one of two forms, chosen per request. In offset form the output is the byte position of the first hit or of the first zero element. In mask form the output marks every hit element as all ones. A 2-bit condition code comes with either form.

Top module: `vrange_scan`

## Requirements
- R1: `in_ready` is high exactly while the unit is idle, and a request is taken only on an edge with `in_valid` and `in_ready` both high. While `out_valid` is high and `out_ready` is low, `out_result` and `out_cc` hold their values and no new request is taken. The edge that sees `out_ready` high returns the unit to idle.
- R2: `in_esz` selects the element size: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, and 3 behaves like 2. Byte 0 is bits [127:120]. Element i occupies bytes i*s to i*s+s-1, where s is the element size, so the vector holds 16/s elements.
- R3: Boundary elements 2k and 2k+1 form group k. A data element matches group k only when both boundaries of that group accept it.
- R4: The acceptance rule of boundary j comes from the byte at position j*s of `in_ctrl`, which is the top byte of control element j. In that byte, bit 7 accepts data equal to the boundary, bit 6 accepts data below it and bit 5 accepts data above it. All comparisons are unsigned. Bits 4..0 of that byte and all other control bytes have no effect.
- R5: An element is a hit when any group matches it. When `in_invert` is 1, each element's hit is complemented.
- R6: In offset form (`in_mask_mode`=0), `out_result[127:64]` holds the byte offset of the first hit, or 16 when there is none. `out_result[63:0]` is zero.
- R7: With `in_zero_srch`=1, the reported offset is the smaller of the first-hit offset and the first-zero offset. With `in_zero_srch`=0, zero elements get no special treatment.
- R8: In mask form (`in_mask_mode`=1), every hit element is all ones in `out_result` and every other element is zero.
- R9: `out_cc` is 3 when there is neither a hit nor a zero, and 1 when there are hits but no zero. It is 2 when the first hit comes before the first zero, and 0 in every other case. In offset form the scan stops at the first zero, so elements after it are not counted as hits.
- R10: In offset form the scan ends at the first hit, or at the first zero when zero search is on. `out_valid` rises i+1 clock edges after the accepting edge, where i is the index of the element that ended the scan. In mask form, or when nothing ends the scan early, it rises after 16/s edges.
- R11: During and just after reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request can be taken |
| in_data | input | 128 | Data vector to scan |
| in_bound | input | 128 | Boundary values |
| in_ctrl | input | 128 | Per-boundary acceptance bytes |
| in_esz | input | 2 | Element size code |
| in_invert | input | 1 | Complement each element's hit |
| in_mask_mode | input | 1 | 1: mask form, 0: offset form |
| in_zero_srch | input | 1 | Enable first-zero search |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken on this edge |
| out_result | output | 128 | Offset or element mask |
| out_cc | output | 2 | Condition code |

## Verification
The bench builds the unit with its default 16-byte vector. At that width the byte, halfword and word sizes give 16, 8 and 4 elements, and every offset from 0 up to the no-hit value 16 can appear. Directed vectors place a hit or a zero at the start, in the middle and nowhere, so the cycle at which the scan stops is checked at both ends. Word-wide values above 0x80000000 test the unsigned comparison. Control bytes with noise in the ignored bits and bytes are checked against clean control bytes.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_st_e;

  localparam int unsigned EL_MAX_BITS = 32;

  // acceptance bit positions inside a control byte
  localparam int unsigned CB_EQ = 7;
  localparam int unsigned CB_LT = 6;
  localparam int unsigned CB_GT = 5;

  localparam logic [1:0] CC_ZERO      = 2'd0;
  localparam logic [1:0] CC_HITS      = 2'd1;
  localparam logic [1:0] CC_HIT_FIRST = 2'd2;
  localparam logic [1:0] CC_NONE      = 2'd3;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    unique case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/vrs_bound_match.sv
module vrs_bound_match
  import vrs_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16
) (
  input  logic [EL_MAX_BITS-1:0] elem,
  input  logic [8*VEC_BYTES-1:0] bnd,
  input  logic [8*VEC_BYTES-1:0] ctl,
  input  logic [1:0]             esz,
  output logic                   hit
);
  localparam int unsigned W  = 8 * VEC_BYTES;
  localparam int unsigned NB = VEC_BYTES;
  localparam int unsigned NP = NB / 2;

  logic [NB-1:0] acc;
  logic [NP-1:0] pair_ok;

  for (genvar j = 0; j < NB; j++) begin : g_bnd
    logic [31:0] bv_b, bv_h, bv_w, bv;
    logic [7:0]  cv_b, cv_h, cv_w, cv;
    logic        in_h, in_w, en;

    assign bv_b = {24'd0, bnd[W-1-8*j -: 8]};
    assign cv_b = ctl[W-1-8*j -: 8];

    if (2*j + 2 <= NB) begin : g_h
      assign bv_h = {16'd0, bnd[W-1-16*j -: 16]};
      assign cv_h = ctl[W-1-16*j -: 8];
      assign in_h = 1'b1;
    end else begin : g_nh
      assign bv_h = '0;
      assign cv_h = '0;
      assign in_h = 1'b0;
    end

    if (4*j + 4 <= NB) begin : g_w
      assign bv_w = bnd[W-1-32*j -: 32];
      assign cv_w = ctl[W-1-32*j -: 8];
      assign in_w = 1'b1;
    end else begin : g_nw
      assign bv_w = '0;
      assign cv_w = '0;
      assign in_w = 1'b0;
    end

    always_comb begin
      unique case (esz)
        2'd0: begin bv = bv_b; cv = cv_b; en = 1'b1; end
        2'd1: begin bv = bv_h; cv = cv_h; en = in_h; end
        default: begin bv = bv_w; cv = cv_w; en = in_w; end
      endcase
    end

    assign acc[j] = en & ((elem == bv) ? cv[CB_EQ] :
                          (elem <  bv) ? cv[CB_LT] : cv[CB_GT]);
  end

  for (genvar k = 0; k < NP; k++) begin : g_pair
    assign pair_ok[k] = acc[2*k] & acc[2*k+1];
  end

  assign hit = |pair_ok;

endmodule

// File: rtl/vrs_zero_find.sv
module vrs_zero_find
  import vrs_pkg::*;
#(
  parameter  int unsigned VEC_BYTES = 16,
  localparam int unsigned OFF_W     = $clog2(VEC_BYTES + 1)
) (
  input  logic [8*VEC_BYTES-1:0] vec,
  input  logic [1:0]             esz,
  input  logic                   enable,
  output logic [OFF_W-1:0]       first_zero
);
  localparam int unsigned W  = 8 * VEC_BYTES;
  localparam int unsigned NB = VEC_BYTES;

  logic [NB-1:0] bz, z_h, z_w, zsel;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign bz[b] = (vec[W-1-8*b -: 8] == 8'd0);
    if ((b % 2 == 0) && (b + 1 < NB)) begin : g_h
      assign z_h[b] = bz[b] & bz[b+1];
    end else begin : g_nh
      assign z_h[b] = 1'b0;
    end
    if ((b % 4 == 0) && (b + 3 < NB)) begin : g_w
      assign z_w[b] = &bz[b+3:b];
    end else begin : g_nw
      assign z_w[b] = 1'b0;
    end
  end

  always_comb begin
    unique case (esz)
      2'd0:    zsel = bz;
      2'd1:    zsel = z_h;
      default: zsel = z_w;
    endcase
    first_zero = OFF_W'(NB);
    if (enable) begin
      for (int b = NB - 1; b >= 0; b--) begin
        if (zsel[b]) first_zero = OFF_W'(b);
      end
    end
  end

endmodule

// File: rtl/vrange_scan.sv
module vrange_scan
  import vrs_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [8*VEC_BYTES-1:0] in_data,
  input  logic [8*VEC_BYTES-1:0] in_bound,
  input  logic [8*VEC_BYTES-1:0] in_ctrl,
  input  logic [1:0]             in_esz,
  input  logic                   in_invert,
  input  logic                   in_mask_mode,
  input  logic                   in_zero_srch,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [8*VEC_BYTES-1:0] out_result,
  output logic [1:0]             out_cc
);
  localparam int unsigned W     = 8 * VEC_BYTES;
  localparam int unsigned HALF  = W / 2;
  localparam int unsigned OFF_W = $clog2(VEC_BYTES + 1);
  localparam logic [OFF_W-1:0] NONE_OFF = OFF_W'(VEC_BYTES);

  scan_st_e         st_q;
  logic [W-1:0]     dat_q, bnd_q, ctl_q, mask_q;
  logic [1:0]       esz_q;
  logic             inv_q, mm_q, zs_q;
  logic [OFF_W-1:0] idx_q, hit_off_q;

  logic [2:0]             s_b;
  logic [5:0]             elem_bits;
  logic [OFF_W-1:0]       cur_byte, zero_off, final_off;
  logic [W-1:0]           dat_sh, elem_ones;
  logic [EL_MAX_BITS-1:0] elem;
  logic                   raw_hit, hit, last_elem, stop_zero;

  assign s_b       = size_bytes(esz_q);
  assign elem_bits = {s_b, 3'b000};
  assign cur_byte  = OFF_W'(idx_q * OFF_W'(s_b));
  assign dat_sh    = dat_q << {cur_byte, 3'b000};
  assign elem      = dat_sh[W-1 -: EL_MAX_BITS] >> (6'd32 - elem_bits);
  assign elem_ones = ({W{1'b1}} ^ ({W{1'b1}} >> elem_bits)) >> {cur_byte, 3'b000};
  assign last_elem = ({1'b0, cur_byte} + {{(OFF_W-2){1'b0}}, s_b}) == (OFF_W+1)'(VEC_BYTES);

  vrs_bound_match #(.VEC_BYTES(VEC_BYTES)) u_match (
    .elem (elem),
    .bnd  (bnd_q),
    .ctl  (ctl_q),
    .esz  (esz_q),
    .hit  (raw_hit)
  );

  vrs_zero_find #(.VEC_BYTES(VEC_BYTES)) u_zero (
    .vec        (dat_q),
    .esz        (esz_q),
    .enable     (zs_q),
    .first_zero (zero_off)
  );

  assign hit       = raw_hit ^ inv_q;
  assign stop_zero = !mm_q && (cur_byte == zero_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      dat_q     <= '0;
      bnd_q     <= '0;
      ctl_q     <= '0;
      mask_q    <= '0;
      esz_q     <= '0;
      inv_q     <= 1'b0;
      mm_q      <= 1'b0;
      zs_q      <= 1'b0;
      idx_q     <= '0;
      hit_off_q <= NONE_OFF;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            dat_q     <= in_data;
            bnd_q     <= in_bound;
            ctl_q     <= in_ctrl;
            esz_q     <= in_esz;
            inv_q     <= in_invert;
            mm_q      <= in_mask_mode;
            zs_q      <= in_zero_srch;
            idx_q     <= '0;
            mask_q    <= '0;
            hit_off_q <= NONE_OFF;
            st_q      <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (stop_zero) begin
            st_q <= ST_DONE;
          end else begin
            if (hit) begin
              if (hit_off_q == NONE_OFF) hit_off_q <= cur_byte;
              mask_q <= mask_q | elem_ones;
            end
            if (last_elem || (hit && !mm_q)) st_q <= ST_DONE;
            else idx_q <= idx_q + 1'b1;
          end
        end
        ST_DONE: begin
          if (out_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign final_off = (hit_off_q < zero_off) ? hit_off_q : zero_off;

  always_comb begin
    if (zero_off == NONE_OFF && hit_off_q == NONE_OFF) out_cc = CC_NONE;
    else if (zero_off == NONE_OFF)                     out_cc = CC_HITS;
    else if (hit_off_q < zero_off)                     out_cc = CC_HIT_FIRST;
    else                                               out_cc = CC_ZERO;
  end

  assign in_ready   = (st_q == ST_IDLE);
  assign out_valid  = (st_q == ST_DONE);
  assign out_result = mm_q ? mask_q
                           : {{(HALF-OFF_W){1'b0}}, final_off, {HALF{1'b0}}};

endmodule

// File: rtl/vrange_scan_chk.sv
module vrange_scan_chk #(
  parameter int unsigned VEC_BYTES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [8*VEC_BYTES-1:0] out_result,
  input logic [1:0]             out_cc,
  input logic                   mask_mode
);
  localparam int unsigned W = 8 * VEC_BYTES;

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cc));

  // R1
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R1
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && !out_valid);

  // R1
  release_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);

  // R6
  offset_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !mask_mode |-> out_result[W/2-1:0] == '0
                              && out_result[W-1:W/2] <= (W/2)'(VEC_BYTES));

  // R9
  offset_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !mask_mode && out_cc == 2'd3 |-> out_result[W-1:W/2] == (W/2)'(VEC_BYTES));

  // R8
  mask_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mask_mode && out_cc == 2'd3 |-> out_result == '0);

  // R8
  mask_some_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mask_mode && (out_cc == 2'd1 || out_cc == 2'd2) |-> out_result != '0);

endmodule

bind vrange_scan vrange_scan_chk #(.VEC_BYTES(VEC_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_cc     (out_cc),
  .mask_mode  (mm_q)
);

// File: tb/vrange_scan_tb.sv
`timescale 1ns/1ps
module vrange_scan_tb;
  localparam int unsigned VB = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [127:0] in_data = '0, in_bound = '0, in_ctrl = '0;
  logic [1:0]   in_esz = '0;
  logic         in_invert = 1'b0, in_mask_mode = 1'b0, in_zero_srch = 1'b0;
  logic         out_valid, out_ready = 1'b0;
  logic [127:0] out_result;
  logic [1:0]   out_cc;

  int n_checks = 0;
  int n_errs   = 0;

  always #2.5 clk = ~clk;

  vrange_scan #(.VEC_BYTES(VB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bound(in_bound), .in_ctrl(in_ctrl),
    .in_esz(in_esz), .in_invert(in_invert), .in_mask_mode(in_mask_mode),
    .in_zero_srch(in_zero_srch),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_cc(out_cc)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model built from the requirements ----------
  function automatic logic [7:0] byte_at(input logic [127:0] v, input int n);
    return v[127-8*n -: 8];
  endfunction

  function automatic logic [31:0] el_at(input logic [127:0] v, input int i, input int s);
    logic [31:0] r = '0;
    for (int b = 0; b < s; b++) r = (r << 8) | 32'(byte_at(v, i*s + b));
    return r;
  endfunction

  function automatic bit accepts(input logic [31:0] d, input logic [31:0] bd, input logic [7:0] c);
    if (d == bd) return c[7];
    if (d < bd)  return c[6];
    return c[5];
  endfunction

  function automatic void model(input logic [127:0] d, b, c, input logic [1:0] esz,
                                input bit inv, mm, zs,
                                output logic [127:0] r, output logic [1:0] cc, output int lat);
    int s, n, fz, fm;
    s = (esz == 2'd0) ? 1 : (esz == 2'd1) ? 2 : 4;
    n = 16 / s;
    fz = 16; fm = 16; lat = n; r = '0;
    if (zs) begin
      for (int i = n - 1; i >= 0; i--) if (el_at(d, i, s) == 0) fz = i * s;
    end
    for (int i = 0; i < n; i++) begin
      bit h = 1'b0;
      if (!mm && i * s == fz) begin lat = i + 1; break; end
      for (int k = 0; k < n / 2; k++) begin
        if (accepts(el_at(d, i, s), el_at(b, 2*k, s), byte_at(c, 2*k*s)) &&
            accepts(el_at(d, i, s), el_at(b, 2*k+1, s), byte_at(c, (2*k+1)*s)))
          h = 1'b1;
      end
      h = h ^ inv;
      if (h) begin
        if (fm == 16) fm = i * s;
        for (int q = 0; q < s; q++) r[127-8*(i*s+q) -: 8] = 8'hFF;
        if (!mm) begin lat = i + 1; break; end
      end
    end
    if (!mm) r = {64'((fm < fz) ? fm : fz), 64'd0};
    if (fz == 16 && fm == 16) cc = 2'd3;
    else if (fz == 16)        cc = 2'd1;
    else if (fm < fz)         cc = 2'd2;
    else                      cc = 2'd0;
  endfunction

  // ---------------- one request through the unit ---------------------------
  task automatic run_case(input logic [127:0] d, b, c, input logic [1:0] esz,
                          input bit inv, mm, zs, hold, input string tag,
                          output logic [127:0] got);
    logic [127:0] er;
    logic [1:0]   ecc;
    int           elat, cnt;
    model(d, b, c, esz, inv, mm, zs, er, ecc, elat);
    @(negedge clk);
    in_data = d; in_bound = b; in_ctrl = c; in_esz = esz;
    in_invert = inv; in_mask_mode = mm; in_zero_srch = zs; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 0;
    while (!out_valid && cnt < 64) begin
      @(posedge clk); cnt++; @(negedge clk);
    end
    check(out_valid, tag, "result valid", 128'(out_valid), 128'd1);
    check(out_result == er, tag, "result", out_result, er);
    check(out_cc == ecc, tag, "cc (R9)", 128'(out_cc), 128'(ecc));
    check(cnt == elat, tag, "R10 latency", 128'(cnt), 128'(elat));
    got = out_result;
    if (hold) begin
      in_valid = 1'b1; in_data = ~d;
      repeat (3) begin
        @(posedge clk); @(negedge clk);
        check(out_valid && !in_ready && out_result == er && out_cc == ecc,
              "R1", "held result", out_result, er);
      end
      in_valid = 1'b0;
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R1", "back to idle", 128'({out_valid, in_ready}), 128'(2'b01));
  endtask

  // ---------------- scenarios ------------------------------------------------
  localparam logic [127:0] LC_BND = {8'h61, 8'h7A, 112'h0};
  localparam logic [127:0] LC_CTL = {8'hA0, 8'hC0, 112'h0};

  task automatic t_reset();
    check(in_ready && !out_valid, "R11", "reset state", 128'({in_ready, out_valid}), 128'(2'b10));
  endtask

  task automatic t_lower_range();
    logic [127:0] g;
    run_case("ABCdEFGHIJKLMNOP", LC_BND, LC_CTL, 2'd0, 0, 0, 0, 0, "R5 R6 byte range", g);
    check(g == {64'd3, 64'd0}, "R6", "first hit offset", g, {64'd3, 64'd0});
    run_case("ABCDEFGHIJKLMNOP", LC_BND, LC_CTL, 2'd0, 0, 0, 0, 0, "R6 no hit", g);
  endtask

  task automatic t_zero_search();
    logic [127:0] g;
    run_case({"ABC", 8'h00, "dEFGHIJKLMNO"}, LC_BND, LC_CTL, 2'd0, 0, 0, 1, 0, "R7 zero first", g);
    run_case({"ABdC", 8'h00, "EFGHIJKLMNO"}, LC_BND, LC_CTL, 2'd0, 0, 0, 1, 0, "R7 hit first", g);
    run_case({"ABC", 8'h00, "dEFGHIJKLMNO"}, LC_BND, LC_CTL, 2'd0, 0, 0, 0, 0, "R7 zero ignored", g);
    check(g == {64'd4, 64'd0}, "R7", "zero ignored offset", g, {64'd4, 64'd0});
    run_case({8'h00, "ABdCEFGHIJKLMNO"}, LC_BND, LC_CTL, 2'd0, 0, 0, 1, 0, "R10 zero at 0", g);
    run_case({"ABdC", 8'h00, "EFGHIJKLMNO"}, LC_BND, LC_CTL, 2'd0, 0, 1, 1, 0, "R8 R9 mask zero", g);
  endtask

  task automatic t_invert();
    logic [127:0] g;
    run_case({"abcde", "F", "ghijklmnop"}, LC_BND, LC_CTL, 2'd0, 1, 0, 0, 0, "R5 invert", g);
    run_case({"abcde", "F", "ghijklmnop"}, LC_BND, LC_CTL, 2'd0, 1, 1, 0, 0, "R5 R8 invert mask", g);
    check(g == {40'd0, 8'hFF, 80'd0}, "R5", "inverted mask", g, {40'd0, 8'hFF, 80'd0});
  endtask

  localparam logic [127:0] HW_DAT = {16'h0005, 16'h1234, 16'h0100, 16'h00FF,
                                     16'h0000, 16'h7FFF, 16'h8000, 16'h0101};
  localparam logic [127:0] HW_BND = {16'h0100, 16'h7FFF, 96'h0};

  task automatic t_half_mask(output logic [127:0] g);
    run_case(HW_DAT, HW_BND, {16'hA000, 16'hC000, 96'h0}, 2'd1, 0, 1, 1, 0, "R2 R8 halfword mask", g);
  endtask

  task automatic t_word_unsigned();
    logic [127:0] d, b, c, g2, g3;
    d = {32'h00000010, 32'h90000000, 32'h7FFFFFFF, 32'hFFFFFFFF};
    b = {32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF};
    c = {32'h20000000, 32'h40000000, 32'h80000000, 32'h80000000};
    run_case(d, b, c, 2'd2, 0, 0, 0, 0, "R2 R4 word unsigned", g2);
    run_case(d, b, c, 2'd3, 0, 0, 0, 0, "R2 size code 3", g3);
    check(g3 == g2, "R2", "code 3 equals code 2", g3, g2);
    run_case(d, b, c, 2'd2, 0, 1, 0, 0, "R4 R8 word mask", g2);
    check(g2 == {32'd0, 64'hFFFFFFFF_FFFFFFFF, 32'd0}, "R4", "unsigned mask", g2,
          {32'd0, 64'hFFFFFFFF_FFFFFFFF, 32'd0});
  endtask

  task automatic t_ctl_ignored(input logic [127:0] half_ref);
    logic [127:0] g;
    run_case("ABCdEFGHIJKLMNOP", LC_BND, {8'hBF, 8'hDF, {14{8'h1F}}}, 2'd0, 0, 0, 0, 0, "R4 noisy ctl bytes", g);
    check(g == {64'd3, 64'd0}, "R4", "low ctl bits ignored", g, {64'd3, 64'd0});
    run_case(HW_DAT, HW_BND, {16'hA0FF, 16'hC07E, {6{16'h1FFF}}}, 2'd1, 0, 1, 1, 0, "R4 noisy ctl halfword", g);
    check(g == half_ref, "R4", "other ctl bytes ignored", g, half_ref);
  endtask

  task automatic t_pair_rule();
    logic [127:0] g, b, c;
    b = {8'h4D, 8'h00, 32'h0, "QQ", 64'h0};
    c = {8'h80, 8'h80, 32'h0, 8'h80, 8'h80, 64'h0};
    run_case("MMMMMMMMMMMMMMMM", b, c, 2'd0, 0, 0, 0, 0, "R3 half pair", g);
    check(g == {64'd16, 64'd0}, "R3", "half-accepted pair no hit", g, {64'd16, 64'd0});
    run_case("MMMMMMMMMMMMMMMM", b, c, 2'd0, 0, 1, 0, 0, "R3 R8 half pair mask", g);
    run_case("MMMMMMMQMMMMMMMM", b, c, 2'd0, 0, 0, 0, 0, "R3 R5 later pair", g);
  endtask

  task automatic t_backpressure();
    logic [127:0] g;
    run_case("xxAxxxxxxxxxxxxx", {8'h41, 8'h41, 112'h0}, {8'h80, 8'h80, 112'h0},
             2'd0, 0, 0, 0, 1, "R1 back-pressure", g);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin : main
    logic [127:0] half_ref;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lower_range();
    t_zero_search();
    t_invert();
    t_half_mask(half_ref);
    t_word_unsigned();
    t_ctl_ignored(half_ref);
    t_pair_rule();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule